// File: doc/BRIEF.md
# Character-Serial Two-Operand Instruction Sequencer

This block reads one instruction at a time, character by character, from a single-port memory that is one character wide. It places the instruction in an internal instruction register and reads its address fields. A long instruction has seven characters: an opcode, an operand-1 start address, and the two end addresses of operand 2. A short instruction has five characters: an opcode, an operand-1 address and one operand-2 address. Four opcode bits set the instruction length, the processing direction, and whether each operand address is indirect. An indirect address points at the memory cells that hold the real address, and the block reads it from there.

After the addresses are settled, the block walks both operands together. On each step it reads one character of operand 1 and the matching character of operand 2. It then offers the pair to an external character processor over a valid/ready interface. When the processor accepts the final character position of operand 2, the block pulses an end-of-instruction strobe for one cycle. It then fetches the next instruction from the address that follows the one just executed.

Addresses are row/column pairs. Each coordinate runs from 1 to 31 and wraps into the next or the previous row. An address stored in memory takes two characters: the row character comes first and the column character second, and only the low five bits of each are used.

Top module: `char_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, the block drives a memory read at row 1, column 1 (mem_addr = {row, col}, five bits each), with pair_valid and instr_done low.
- R2: Opcode bit 1 sets the instruction length: 1 gives 7 characters and 0 gives 5. The characters are read at consecutive addresses, starting at the instruction counter.
- R3: The next fetch starts at the address just after the last character of the previous instruction. Stepping past column 31 goes to column 1 of the next row, and row 31 wraps to row 1. The first read of the fetch is issued in the cycle after instr_done.
- R4: Opcode bit 0 = 0 selects ascending mode. Operand 2 runs from its last address (field C) back to its first address (field B), and operand 1 starts at field A. Both pointers step down, and stepping below column 1 goes to column 31 of the previous row.
- R5: Opcode bit 0 = 1 selects descending mode. Operand 2 runs from field B up to field C, operand 1 starts at field A, and both pointers step up.
- R6: One pair is offered for each character position of operand 2. pair_last is high only on the final pair. instr_done is high for exactly one cycle, in the cycle after that final pair is accepted.
- R7: When pair_valid is high and pair_ready is low, pair_valid, pair_op1, pair_op2 and pair_last keep their values in the next cycle. A pair counts as transferred only in a cycle where pair_valid and pair_ready are both high.
- R8: Opcode bit 2 = 1 makes operand 1 indirect. The two characters at field A (row character, then column character) are read and used as operand 1's start address.
- R9: Opcode bit 3 = 1 makes operand 2 indirect. Reading starts at field B. For a long instruction, four characters are read (new B row and column, then new C row and column). For a short instruction, two characters are read (new B). Operand-1 indirection is resolved first.
- R10: A short instruction has a one-character operand 2 at field B, so it produces exactly one pair.
- R11: Only the low five bits of an address character form the coordinate. Bit 5 is ignored.
- R12: No memory read is issued in any cycle in which a pair is offered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 10 | Read address, {row, col} |
| mem_rdata | input | 6 | Read data, valid one cycle after mem_rd |
| pair_valid | output | 1 | A character pair is offered |
| pair_ready | input | 1 | The processor accepts the pair |
| pair_op1 | output | 6 | Operand-1 character |
| pair_op2 | output | 6 | Operand-2 character |
| pair_opcode | output | 6 | Opcode of the current instruction |
| pair_last | output | 1 | This pair is the final operand-2 position |
| instr_done | output | 1 | One-cycle end-of-instruction strobe |

## Verification
The assertions assume that the memory always returns read data exactly one cycle after mem_rd and never stalls. They also assume that the processor may hold pair_ready low for any number of cycles. The bench's memory model is a registered array with that fixed latency. During one instruction the bench toggles pair_ready on every cycle to exercise back-pressure. The assertions also assume that operand 2's B and C fields are ordered correctly for the selected mode, so that the walk reaches the end address quickly. Every instruction in the bench program places its operands within the same or the adjacent row, in the order its mode expects.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int CHAR_W  = 6;
  localparam int COORD_W = 5;
  localparam int ADDR_W  = 2 * COORD_W;
  localparam int IR_LEN  = 7;
  localparam int IDX_W   = $clog2(IR_LEN + 1);

  // opcode bit positions
  localparam int OPB_DESC = 0;
  localparam int OPB_LONG = 1;
  localparam int OPB_IND1 = 2;
  localparam int OPB_IND2 = 3;

  typedef struct packed {
    logic [COORD_W-1:0] row;
    logic [COORD_W-1:0] col;
  } rc_t;

  typedef enum logic [1:0] {PH_FETCH, PH_IND1, PH_IND2} phase_t;

  typedef enum logic [3:0] {
    S_LREQ, S_LCAP, S_DEC, S_DISP, S_RD1, S_CAP1, S_CAP2, S_OUT, S_DONE
  } state_t;

  function automatic rc_t to_rc(input logic [CHAR_W-1:0] hi, input logic [CHAR_W-1:0] lo);
    rc_t r;
    r.row = hi[COORD_W-1:0];
    r.col = lo[COORD_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/seq_decode.sv
module seq_decode import seq_pkg::*; (
  input  logic [CHAR_W-1:0] opc,
  output logic              desc,
  output logic              lng,
  output logic              ind1,
  output logic              ind2,
  output logic [IDX_W-1:0]  last_idx
);
  always_comb begin
    desc     = opc[OPB_DESC];
    lng      = opc[OPB_LONG];
    ind1     = opc[OPB_IND1];
    ind2     = opc[OPB_IND2];
    last_idx = lng ? IDX_W'(IR_LEN - 1) : IDX_W'(IR_LEN - 3);
  end
endmodule

// File: rtl/rc_step.sv
module rc_step import seq_pkg::*; (
  input  rc_t  cur,
  input  logic down,
  output rc_t  nxt
);
  localparam logic [COORD_W-1:0] TOP = '1;
  localparam logic [COORD_W-1:0] ONE = COORD_W'(1);

  always_comb begin
    nxt = cur;
    if (!down) begin
      if (cur.col == TOP) begin
        nxt.col = ONE;
        nxt.row = (cur.row == TOP) ? ONE : cur.row + ONE;
      end else begin
        nxt.col = cur.col + ONE;
      end
    end else begin
      if (cur.col == ONE) begin
        nxt.col = TOP;
        nxt.row = (cur.row == ONE) ? TOP : cur.row - ONE;
      end else begin
        nxt.col = cur.col - ONE;
      end
    end
  end
endmodule

// File: rtl/char_seq.sv
module char_seq import seq_pkg::*; #(
  parameter int START_ROW = 1,
  parameter int START_COL = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [CHAR_W-1:0] mem_rdata,
  output logic              pair_valid,
  input  logic              pair_ready,
  output logic [CHAR_W-1:0] pair_op1,
  output logic [CHAR_W-1:0] pair_op2,
  output logic [CHAR_W-1:0] pair_opcode,
  output logic              pair_last,
  output logic              instr_done
);
  localparam int NSTEP = 3;
  localparam rc_t START = '{row: COORD_W'(START_ROW), col: COORD_W'(START_COL)};

  state_t            state;
  phase_t            phase;
  logic [CHAR_W-1:0] ir [IR_LEN];
  logic [IDX_W-1:0]  idx, lend;
  rc_t               ld_ptr, icc, p1, p2, end2;
  logic [CHAR_W-1:0] ch1, ch2;
  logic              desc_q, long_q, pend1, pend2;

  // opcode decode: during the first fetch capture the opcode is still on the bus
  logic [CHAR_W-1:0] dec_in;
  logic              d_desc, d_long, d_ind1, d_ind2;
  logic [IDX_W-1:0]  d_last;
  assign dec_in = (state == S_LCAP && phase == PH_FETCH && idx == '0) ? mem_rdata : ir[0];
  seq_decode u_dec (.opc(dec_in), .desc(d_desc), .lng(d_long), .ind1(d_ind1),
                    .ind2(d_ind2), .last_idx(d_last));

  // address steppers: load pointer, operand-1 pointer, operand-2 pointer
  rc_t  st_in  [NSTEP];
  logic st_dn  [NSTEP];
  rc_t  st_out [NSTEP];
  assign st_in[0] = ld_ptr;
  assign st_dn[0] = 1'b0;
  assign st_in[1] = p1;
  assign st_dn[1] = !desc_q;
  assign st_in[2] = p2;
  assign st_dn[2] = !desc_q;
  for (genvar g = 0; g < NSTEP; g++) begin : g_step
    rc_step u_step (.cur(st_in[g]), .down(st_dn[g]), .nxt(st_out[g]));
  end

  rc_t fld_a, fld_b, fld_c;
  assign fld_a = to_rc(ir[1], ir[2]);
  assign fld_b = to_rc(ir[3], ir[4]);
  assign fld_c = long_q ? to_rc(ir[5], ir[6]) : fld_b;

  logic ld_last, at_end;
  assign ld_last = (phase == PH_FETCH) ? (idx == d_last) : (idx == lend);
  assign at_end  = (p2 == end2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_LREQ;
      phase  <= PH_FETCH;
      idx    <= '0;
      lend   <= '0;
      ld_ptr <= START;
      icc    <= START;
      p1     <= '0;
      p2     <= '0;
      end2   <= '0;
      ch1    <= '0;
      ch2    <= '0;
      desc_q <= 1'b0;
      long_q <= 1'b0;
      pend1  <= 1'b0;
      pend2  <= 1'b0;
      for (int i = 0; i < IR_LEN; i++) ir[i] <= '0;
    end else begin
      case (state)
        S_LREQ: state <= S_LCAP;
        S_LCAP: begin
          ir[idx] <= mem_rdata;
          ld_ptr  <= st_out[0];
          idx     <= idx + 1'b1;
          if (ld_last) begin
            if (phase == PH_FETCH) begin
              icc   <= st_out[0];
              state <= S_DEC;
            end else begin
              state <= S_DISP;
            end
          end else begin
            state <= S_LREQ;
          end
        end
        S_DEC: begin
          desc_q <= d_desc;
          long_q <= d_long;
          pend1  <= d_ind1;
          pend2  <= d_ind2;
          state  <= S_DISP;
        end
        S_DISP: begin
          if (pend1) begin
            pend1  <= 1'b0;
            phase  <= PH_IND1;
            ld_ptr <= fld_a;
            idx    <= IDX_W'(1);
            lend   <= IDX_W'(2);
            state  <= S_LREQ;
          end else if (pend2) begin
            pend2  <= 1'b0;
            phase  <= PH_IND2;
            ld_ptr <= fld_b;
            idx    <= IDX_W'(3);
            lend   <= long_q ? IDX_W'(6) : IDX_W'(4);
            state  <= S_LREQ;
          end else begin
            p1    <= fld_a;
            p2    <= desc_q ? fld_b : fld_c;
            end2  <= desc_q ? fld_c : fld_b;
            state <= S_RD1;
          end
        end
        S_RD1:  state <= S_CAP1;
        S_CAP1: begin
          ch1   <= mem_rdata;
          state <= S_CAP2;
        end
        S_CAP2: begin
          ch2   <= mem_rdata;
          state <= S_OUT;
        end
        S_OUT: begin
          if (pair_ready) begin
            if (at_end) begin
              state <= S_DONE;
            end else begin
              p1    <= st_out[1];
              p2    <= st_out[2];
              state <= S_RD1;
            end
          end
        end
        S_DONE: begin
          phase  <= PH_FETCH;
          idx    <= '0;
          ld_ptr <= icc;
          state  <= S_LREQ;
        end
        default: state <= S_LREQ;
      endcase
    end
  end

  always_comb begin
    mem_rd   = (state == S_LREQ) || (state == S_RD1) || (state == S_CAP1);
    mem_addr = ld_ptr;
    if (state == S_RD1)  mem_addr = p1;
    if (state == S_CAP1) mem_addr = p2;
  end

  assign pair_valid  = (state == S_OUT);
  assign pair_op1    = ch1;
  assign pair_op2    = ch2;
  assign pair_opcode = ir[0];
  assign pair_last   = (state == S_OUT) && at_end;
  assign instr_done  = (state == S_DONE);
endmodule

// File: rtl/char_seq_checker.sv
module char_seq_checker import seq_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd,
  input logic              pair_valid,
  input logic              pair_ready,
  input logic [CHAR_W-1:0] pair_op1,
  input logic [CHAR_W-1:0] pair_op2,
  input logic              pair_last,
  input logic              instr_done
);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |=> !instr_done);

  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |-> $past(pair_valid && pair_ready && pair_last));

  assert_last_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pair_last |-> pair_valid);

  assert_hold_under_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid && !pair_ready |=> pair_valid && $stable(pair_op1) && $stable(pair_op2)
                                   && $stable(pair_last));

  assert_fetch_follows_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |=> mem_rd);

  assert_port_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> !mem_rd);
endmodule

bind char_seq char_seq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .pair_valid(pair_valid),
  .pair_ready(pair_ready), .pair_op1(pair_op1), .pair_op2(pair_op2),
  .pair_last(pair_last), .instr_done(instr_done)
);

// File: tb/char_seq_bench.sv
`timescale 1ns/1ps
module char_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mem_rd;
  logic [9:0] mem_addr;
  logic [5:0] mem_rdata;
  logic       pair_valid;
  logic       pair_ready = 1'b1;
  logic [5:0] pair_op1, pair_op2, pair_opcode;
  logic       pair_last, instr_done;

  always #4 clk = ~clk;

  char_seq u_char_seq (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .pair_valid(pair_valid), .pair_ready(pair_ready),
    .pair_op1(pair_op1), .pair_op2(pair_op2), .pair_opcode(pair_opcode),
    .pair_last(pair_last), .instr_done(instr_done)
  );

  logic [5:0] mem [1024];
  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

  int rlog [4096];
  int nlog = 0;
  always @(negedge clk) if (rst_n && mem_rd && nlog < 4096) begin
    rlog[nlog] = int'(mem_addr);
    nlog = nlog + 1;
  end

  int n_chk = 0, n_fail = 0, cyc = 0, base = 0;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 20000) begin
      n_chk = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic int rc(input int r, input int c);
    return r * 32 + c;
  endfunction

  function automatic int stp(input int a, input bit down);
    int r = a / 32, c = a % 32;
    if (!down) begin
      if (c == 31) begin c = 1; r = (r == 31) ? 1 : r + 1; end else c = c + 1;
    end else begin
      if (c == 1) begin c = 31; r = (r == 1) ? 31 : r - 1; end else c = c - 1;
    end
    return r * 32 + c;
  endfunction

  int pc = 33;  // row 1 col 1
  task automatic put(input int v);
    mem[pc] = 6'(v);
    pc = stp(pc, 1'b0);
  endtask

  // generic instruction check
  task automatic run_check(input string rq, input int fetch_a, input int len,
                           input int ptr1, input int ptr2, input int n_ind2,
                           input int op1_a, input int op2_a, input bit desc,
                           input int npairs, input bit bp);
    int extra = (ptr1 >= 0 ? 2 : 0) + (ptr2 >= 0 ? n_ind2 : 0);
    int a1 = op1_a, a2 = op2_a, k = 0, fa;
    bit held = 0;
    logic [5:0] h1 = '0, h2 = '0;
    while (k < npairs) begin
      @(negedge clk);
      pair_ready = bp ? ~pair_ready : 1'b1;
      if (pair_valid && held) begin
        chk(pair_op1 == h1 && pair_op2 == h2, "R7", "stalled pair changed", int'(pair_op1), int'(h1));
      end
      held = 0;
      if (pair_valid && k == 0) chk(mem_rd == 1'b0, "R12", "read during offer", int'(mem_rd), 0);
      if (pair_valid && pair_ready) begin
        chk(pair_op1 == mem[a1], rq, "op1 char", int'(pair_op1), int'(mem[a1]));
        chk(pair_op2 == mem[a2], rq, "op2 char", int'(pair_op2), int'(mem[a2]));
        chk(pair_last == (k == npairs - 1), "R6", "pair_last", int'(pair_last), int'(k == npairs - 1));
        a1 = stp(a1, !desc);
        a2 = stp(a2, !desc);
        k = k + 1;
      end else if (pair_valid) begin
        held = 1; h1 = pair_op1; h2 = pair_op2;
      end
    end
    @(negedge clk);
    pair_ready = 1'b1;
    chk(instr_done == 1'b1, "R6", "instr_done after last pair", int'(instr_done), 1);
    chk(nlog - base == len + extra + 2 * npairs, rq, "read count", nlog - base, len + extra + 2 * npairs);
    chk(rlog[base] == fetch_a, "R3", "fetch start", rlog[base], fetch_a);
    fa = fetch_a;
    for (int i = 1; i < len; i++) fa = stp(fa, 1'b0);
    chk(rlog[base + len - 1] == fa, "R2", "last fetch address", rlog[base + len - 1], fa);
    if (ptr1 >= 0) chk(rlog[base + len] == ptr1, "R8", "op1 pointer read", rlog[base + len], ptr1);
    if (ptr2 >= 0) chk(rlog[base + len + (ptr1 >= 0 ? 2 : 0)] == ptr2, "R9", "op2 pointer read",
                       rlog[base + len + (ptr1 >= 0 ? 2 : 0)], ptr2);
    chk(rlog[base + len + extra] == op1_a, rq, "first op1 address", rlog[base + len + extra], op1_a);
    chk(rlog[base + len + extra + 1] == op2_a, rq, "first op2 address", rlog[base + len + extra + 1], op2_a);
    base = nlog;
  endtask

  task automatic t_reset();  // R1
    @(negedge clk);
    chk(mem_rd == 1'b1, "R1", "read after reset", int'(mem_rd), 1);
    chk(int'(mem_addr) == rc(1, 1), "R1", "first address", int'(mem_addr), rc(1, 1));
    chk(pair_valid == 1'b0 && instr_done == 1'b0, "R1", "idle outputs", int'(pair_valid), 0);
  endtask

  // long ascending, 4 pairs
  task automatic t_long_asc();
    run_check("R4", rc(1, 1), 7, -1, -1, 0, rc(10, 5), rc(12, 6), 1'b0, 4, 1'b0);
  endtask
  // long descending across a row boundary, with back-pressure
  task automatic t_long_desc_bp();
    run_check("R5", rc(1, 8), 7, -1, -1, 0, rc(11, 30), rc(13, 30), 1'b1, 4, 1'b1);
  endtask
  // short, single pair
  task automatic t_short();
    run_check("R10", rc(1, 15), 5, -1, -1, 0, rc(15, 1), rc(16, 7), 1'b0, 1, 1'b0);
  endtask
  // operand-1 indirect; pointer row char has bit 5 set (R11)
  task automatic t_ind1();
    run_check("R8", rc(1, 20), 7, rc(20, 1), -1, 0, rc(17, 10), rc(18, 1), 1'b1, 3, 1'b0);
    chk(rlog[base - 6] == rc(17, 10), "R11", "op1 address ignores bit 5", rlog[base - 6], rc(17, 10));
  endtask
  // operand-2 indirect long, fetch straddles column 31
  task automatic t_ind2_wrap();
    run_check("R9", rc(1, 27), 7, -1, rc(21, 1), 4, rc(19, 20), rc(22, 7), 1'b0, 3, 1'b0);
  endtask
  // short with both indirections
  task automatic t_ind_both_short();
    run_check("R9", rc(2, 3), 5, rc(23, 1), rc(23, 3), 2, rc(24, 9), rc(25, 2), 1'b0, 1, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 6'((i * 5 + 1) % 64);
    // I1 long asc: A=(10,5) B=(12,3) C=(12,6)
    put(2);  put(10); put(5);  put(12); put(3);  put(12); put(6);
    // I2 long desc: A=(11,30) B=(13,30) C=(14,2)
    put(3);  put(11); put(30); put(13); put(30); put(14); put(2);
    // I3 short asc: A=(15,1) B=(16,7)
    put(0);  put(15); put(1);  put(16); put(7);
    // I4 long desc, op1 indirect via (20,1): B=(18,1) C=(18,3)
    put(7);  put(20); put(1);  put(18); put(1);  put(18); put(3);
    // I5 long asc, op2 indirect via (21,1): A=(19,20)
    put(10); put(19); put(20); put(21); put(1);  put(0);  put(0);
    // I6 short, both indirect: A->(23,1) B->(23,3)
    put(12); put(23); put(1);  put(23); put(3);
    mem[rc(20, 1)] = 6'(32 + 17); mem[rc(20, 2)] = 6'(10);
    mem[rc(21, 1)] = 6'(22); mem[rc(21, 2)] = 6'(5);
    mem[rc(21, 3)] = 6'(22); mem[rc(21, 4)] = 6'(7);
    mem[rc(23, 1)] = 6'(24); mem[rc(23, 2)] = 6'(9);
    mem[rc(23, 3)] = 6'(25); mem[rc(23, 4)] = 6'(2);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_long_asc();
    t_long_desc_bp();
    t_short();
    t_ind1();
    t_ind2_wrap();
    t_ind_both_short();
    summary();
  end
endmodule